// File: doc/BRIEF.md
# Converter Power-State Supervisor

This block is the sequencing state machine that sits above a battery DC-DC converter. It decides which of two switching engines may drive the power stage: a free-running start-up oscillator used to lift the output from a low battery voltage, or the digital regulation controller that takes over once the output is high enough. It also reacts to output collapse in two steps: it first drops back to start-up drive, and if the output keeps falling it stops all switching. It pauses the converter during an over-temperature event in PWM operation. It gates an auxiliary load switch and passes the low-battery indication through in every state.

All inputs are logic-level flags produced by analog comparators outside the block. The two output-voltage threshold flags are filtered by a programmable debounce so that ripple near a threshold does not make the state machine chatter. The shutdown input is the strongest input: it removes every enable in the same cycle, and on release the sequence always begins again from start-up mode.

Top module: `conv_pwr_supervisor`

## Requirements
- R1: While `shdn_i` is high, `osc_en_o`, `ctl_en_o` and `aux_on_o` are low in that same cycle, whatever the other inputs are. The supervisor enters its off state at the next clock edge.
- R2: One clock edge after `shdn_i` falls, the supervisor is in start-up mode: `ctl_en_o` is low and `osc_en_o` equals `batt_ok_i`.
- R3: `osc_en_o` is high only in start-up or fallback mode, and only while `batt_ok_i` is high.
- R4: In start-up or fallback mode, a filtered high on `vreg_ok_i` moves control to the digital controller at the next edge. `ctl_en_o` then rises and `osc_en_o` falls together, and the two are never high at once.
- R5: A threshold flag is taken as changed only after its raw value has differed from the filtered value on DEBOUNCE_CYC consecutive clock edges. The resulting state change shows at the outputs DEBOUNCE_CYC+1 edges after the raw change. A shorter excursion has no effect.
- R6: In regulation, a filtered low on `vreg_ok_i` while `vmin_ok_i` stays high returns the supervisor to start-up drive (fallback mode).
- R7: In regulation or fallback mode, a filtered low on `vmin_ok_i` stops all switching. The stopped state holds until a shutdown cycle, even if both flags recover. During the first start-up after shutdown, `vmin_ok_i` is ignored.
- R8: In regulation with `pwm_mode_i` high, a high on `hot_i` turns off the converter and the auxiliary switch at the next edge. Both resume at the edge after `hot_i` returns low. `hot_i` has no effect while `pwm_mode_i` is low.
- R9: `aux_on_o` is high exactly when `aux_ctl_i` is low and the supervisor is neither shut down, nor in its off state, nor in thermal stop.
- R10: `batt_low_o` is the inverse of `batt_ok_i` in every state, including shutdown and reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| shdn_i | input | 1 | Shutdown request, high = shut down |
| batt_ok_i | input | 1 | Battery detector reports sufficient input voltage |
| vreg_ok_i | input | 1 | Output above the regulation threshold (raw) |
| vmin_ok_i | input | 1 | Output above the lower stop threshold (raw) |
| hot_i | input | 1 | Die over-temperature flag, hysteresis applied outside |
| pwm_mode_i | input | 1 | Converter currently in PWM operation |
| aux_ctl_i | input | 1 | Auxiliary switch control, low = on |
| osc_en_o | output | 1 | Enable for the start-up oscillator |
| ctl_en_o | output | 1 | Enable for the digital regulation controller |
| aux_on_o | output | 1 | Auxiliary load switch on |
| batt_low_o | output | 1 | Low-battery indication |

## Verification
The assertions take all flags to be synchronous to `clk`; metastability filtering is left to the comparator interface. They also take `hot_i` to already carry its own hysteresis, so a single high sample counts as a real event. The stimulus changes inputs only a few nanoseconds after a rising edge and keeps each threshold flag level between deliberate changes. Glitch lengths are swept around the debounce window, so that the filter boundary and the stop-hold behaviour are seen with legal inputs.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_STARTUP  = 3'd1,
    ST_FALLBACK = 3'd2,
    ST_REGULATE = 3'd3,
    ST_HOT      = 3'd4,
    ST_STOPPED  = 3'd5
  } pss_state_e;
endpackage

// File: rtl/pss_debounce.sv
module pss_debounce #(
  parameter int DEBOUNCE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = (DEBOUNCE_CYC < 2) ? 1 : $clog2(DEBOUNCE_CYC);
  localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          filt_q, filt_d;

  always_comb begin
    cnt_d  = cnt_q;
    filt_d = filt_q;
    if (raw_i == filt_q) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      filt_d = raw_i;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/pss_fsm.sv
module pss_fsm
  import pss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shdn_i,
  input  logic       vreg_f_i,
  input  logic       vmin_f_i,
  input  logic       hot_i,
  input  logic       pwm_mode_i,
  output pss_state_e st_o
);
  pss_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (shdn_i) begin
      st_d = ST_OFF;
    end else begin
      case (st_q)
        ST_OFF:      st_d = ST_STARTUP;
        ST_STARTUP:  if (vreg_f_i) st_d = ST_REGULATE;
        ST_FALLBACK: begin
          if (!vmin_f_i)     st_d = ST_STOPPED;
          else if (vreg_f_i) st_d = ST_REGULATE;
        end
        ST_REGULATE: begin
          if (hot_i && pwm_mode_i) st_d = ST_HOT;
          else if (!vmin_f_i)      st_d = ST_STOPPED;
          else if (!vreg_f_i)      st_d = ST_FALLBACK;
        end
        ST_HOT:      if (!hot_i) st_d = ST_REGULATE;
        ST_STOPPED:  st_d = ST_STOPPED;
        default:     st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/pss_outdec.sv
module pss_outdec
  import pss_pkg::*;
(
  input  pss_state_e st_i,
  input  logic       shdn_i,
  input  logic       batt_ok_i,
  input  logic       aux_ctl_i,
  output logic       osc_en_o,
  output logic       ctl_en_o,
  output logic       aux_on_o,
  output logic       batt_low_o
);
  logic in_start;

  always_comb begin
    in_start   = (st_i == ST_STARTUP) || (st_i == ST_FALLBACK);
    osc_en_o   = !shdn_i && batt_ok_i && in_start;
    ctl_en_o   = !shdn_i && (st_i == ST_REGULATE);
    aux_on_o   = !shdn_i && !aux_ctl_i && (st_i != ST_OFF) && (st_i != ST_HOT);
    batt_low_o = !batt_ok_i;
  end
endmodule

// File: rtl/conv_pwr_supervisor.sv
module conv_pwr_supervisor
  import pss_pkg::*;
#(
  parameter int DEBOUNCE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shdn_i,
  input  logic batt_ok_i,
  input  logic vreg_ok_i,
  input  logic vmin_ok_i,
  input  logic hot_i,
  input  logic pwm_mode_i,
  input  logic aux_ctl_i,
  output logic osc_en_o,
  output logic ctl_en_o,
  output logic aux_on_o,
  output logic batt_low_o
);
  localparam int NFLAG = 2;

  logic [NFLAG-1:0] raw_vec;
  logic [NFLAG-1:0] filt_vec;
  logic             vreg_f;
  logic             vmin_f;
  pss_state_e       st;

  assign raw_vec = {vmin_ok_i, vreg_ok_i};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flt
    pss_debounce #(.DEBOUNCE_CYC(DEBOUNCE_CYC)) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_vec[g]),
      .filt_o (filt_vec[g])
    );
  end

  assign vreg_f = filt_vec[0];
  assign vmin_f = filt_vec[1];

  pss_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .shdn_i     (shdn_i),
    .vreg_f_i   (vreg_f),
    .vmin_f_i   (vmin_f),
    .hot_i      (hot_i),
    .pwm_mode_i (pwm_mode_i),
    .st_o       (st)
  );

  pss_outdec u_dec (
    .st_i       (st),
    .shdn_i     (shdn_i),
    .batt_ok_i  (batt_ok_i),
    .aux_ctl_i  (aux_ctl_i),
    .osc_en_o   (osc_en_o),
    .ctl_en_o   (ctl_en_o),
    .aux_on_o   (aux_on_o),
    .batt_low_o (batt_low_o)
  );
endmodule

// File: rtl/pss_chk.sv
module pss_chk
  import pss_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       shdn,
  input logic       batt_ok,
  input logic       hot,
  input logic       pwm,
  input logic       vreg_raw,
  input logic       vreg_f,
  input logic       osc_en,
  input logic       ctl_en,
  input logic       aux_on,
  input pss_state_e st
);
  AST_SHDN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |-> (!osc_en && !ctl_en && !aux_on)); // R1

  AST_SHDN_TO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |=> (st == ST_OFF)); // R1

  AST_RELEASE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shdn) |=> (st == ST_STARTUP)); // R2

  AST_OSC_NEEDS_BATT: assert property (@(posedge clk) disable iff (!rst_n)
    !batt_ok |-> !osc_en); // R3

  AST_ONE_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
    !(osc_en && ctl_en)); // R4

  AST_FILT_FOLLOWS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vreg_f) |-> (vreg_f == $past(vreg_raw))); // R5

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOPPED && !shdn) |=> (st == ST_STOPPED)); // R7

  AST_HOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REGULATE && hot && pwm && !shdn) |=> (!ctl_en && !aux_on)); // R8
endmodule

bind conv_pwr_supervisor pss_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .shdn     (shdn_i),
  .batt_ok  (batt_ok_i),
  .hot      (hot_i),
  .pwm      (pwm_mode_i),
  .vreg_raw (vreg_ok_i),
  .vreg_f   (vreg_f),
  .osc_en   (osc_en_o),
  .ctl_en   (ctl_en_o),
  .aux_on   (aux_on_o),
  .st       (st)
);

// File: tb/conv_pwr_supervisor_bench.sv
module conv_pwr_supervisor_bench;
  localparam int DB = 4;

  logic clk = 1'b0;
  logic rst_n, shdn, batt_ok, vreg, vmin, hot, pwm, aux_ctl;
  logic osc_en, ctl_en, aux_on, batt_low;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  conv_pwr_supervisor #(.DEBOUNCE_CYC(DB)) u_conv_pwr_supervisor (
    .clk(clk), .rst_n(rst_n), .shdn_i(shdn), .batt_ok_i(batt_ok),
    .vreg_ok_i(vreg), .vmin_ok_i(vmin), .hot_i(hot), .pwm_mode_i(pwm),
    .aux_ctl_i(aux_ctl), .osc_en_o(osc_en), .ctl_en_o(ctl_en),
    .aux_on_o(aux_on), .batt_low_o(batt_low)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; shdn = 1'b1; batt_ok = 1'b0; vreg = 1'b0; vmin = 1'b0;
    hot = 1'b0; pwm = 1'b0; aux_ctl = 1'b1;
    tick(2);
    chk("R1 reset osc", osc_en, 1'b0);
    chk("R1 reset ctl", ctl_en, 1'b0);
    chk("R1 reset aux", aux_on, 1'b0);
    chk("R10 low in reset", batt_low, 1'b1);
    batt_ok = 1'b1; #1;
    chk("R10 follows in shutdown", batt_low, 1'b0);
    rst_n = 1'b1;
    tick(1);
    shdn = 1'b0;
    tick(1);
    chk("R2 startup osc", osc_en, 1'b1);
    chk("R2 startup ctl", ctl_en, 1'b0);
    batt_ok = 1'b0; #1;
    chk("R3 osc needs battery", osc_en, 1'b0);
    chk("R10 low battery", batt_low, 1'b1);
    batt_ok = 1'b1;
    tick(2 * DB + 2);
    chk("R7 vmin ignored in startup", osc_en, 1'b1);
    aux_ctl = 1'b0; #1;
    chk("R9 aux on in startup", aux_on, 1'b1);

    vmin = 1'b1; vreg = 1'b1;
    tick(DB);
    chk("R5 not yet handed over", ctl_en, 1'b0);
    tick(1);
    chk("R4 ctl enabled", ctl_en, 1'b1);
    chk("R4 osc released", osc_en, 1'b0);
    aux_ctl = 1'b1; #1;
    chk("R9 aux off by control", aux_on, 1'b0);
    aux_ctl = 1'b0; #1;
    chk("R9 aux on by control", aux_on, 1'b1);

    hot = 1'b1;
    tick(3);
    chk("R8 hot ignored without pwm", ctl_en, 1'b1);
    pwm = 1'b1;
    tick(1);
    chk("R8 thermal stop ctl", ctl_en, 1'b0);
    chk("R8 thermal stop aux", aux_on, 1'b0);
    hot = 1'b0;
    tick(1);
    chk("R8 resume ctl", ctl_en, 1'b1);
    chk("R8 resume aux", aux_on, 1'b1);
    pwm = 1'b0;

    vreg = 1'b0;
    tick(DB);
    chk("R5 still regulating", ctl_en, 1'b1);
    tick(1);
    chk("R6 fallback ctl", ctl_en, 1'b0);
    chk("R6 fallback osc", osc_en, 1'b1);
    vreg = 1'b1;
    tick(DB + 1);
    chk("R4 back to regulation", ctl_en, 1'b1);
    vreg = 1'b0;
    tick(DB + 1);
    chk("R6 fallback again", osc_en, 1'b1);
    vmin = 1'b0;
    tick(DB + 1);
    chk("R7 stop osc", osc_en, 1'b0);
    chk("R7 stop ctl", ctl_en, 1'b0);
    vmin = 1'b1; vreg = 1'b1;
    tick(2 * DB + 2);
    chk("R7 stop holds osc", osc_en, 1'b0);
    chk("R7 stop holds ctl", ctl_en, 1'b0);
    chk("R9 aux on while stopped", aux_on, 1'b1);

    shdn = 1'b1;
    tick(1);
    shdn = 1'b0;
    tick(1);
    chk("R2 restart osc", osc_en, 1'b1);
    tick(1);
    chk("R4 regulation after restart", ctl_en, 1'b1);
    shdn = 1'b1; #1;
    chk("R1 ctl dropped at once", ctl_en, 1'b0);
    chk("R1 aux dropped at once", aux_on, 1'b0);
    tick(3);
    chk("R1 stays off", ctl_en, 1'b0);
    shdn = 1'b0;
    tick(1);
    chk("R2 release osc", osc_en, 1'b1);
    chk("R2 release ctl", ctl_en, 1'b0);

    for (int len = 1; len <= DB + 2; len++) begin
      shdn = 1'b1; vreg = 1'b0;
      tick(DB + 2);
      shdn = 1'b0;
      tick(1);
      vreg = 1'b1;
      tick(len);
      vreg = 1'b0;
      if (len < DB + 1) tick(DB + 1 - len);
      chk($sformatf("R5 glitch len=%0d", len), ctl_en, (len >= DB) ? 1'b1 : 1'b0);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule